// File: doc/BRIEF.md
# Level-Stepped Edge-Capture Bit Register

This block stores a single data bit that is captured when a slow, data-like clock input goes from low to high. It does not use that input as a real clock. A fast system clock samples the slow clock input and the data input on every cycle. A two-bit state machine then moves through its four states to detect the rising level change. The captured bit appears as the main output. The second state bit is also visible, so the internal phase of the machine can be watched from outside.

Each system cycle applies exactly one step of the table below. With the state written as {p,q}:

- **Stable states.** State 00 and state 11 stay where they are while the sampled clock input is low.
- **Capture.** When the sampled clock input is high in 00 or 11, the state moves to 01 if data is 1, or to 10 if data is 0.
- **Wait.** The two mixed states, 01 and 10, hold for as long as the clock input stays high, whatever the data does.
- **Settle.** When the clock input returns low, state 01 becomes 11 and state 10 becomes 00.

A one-cycle pulse marks each system cycle in which the stored bit takes a new value. A synchronous active-high reset returns the machine to state 00.

Top module: `pq_edge_register`

## Requirements
- R1: While rst is 1 at a system clock edge, the next cycle shows p_out=0, q_out=0 and q_changed=0.
- R2: In state {p,q}=00 with slow_clk=0, the state stays 00 on the next cycle.
- R3: In state 00 or state 11 with slow_clk=1, the next state is 01 when data_in=1 and 10 when data_in=0.
- R4: In state 11 with slow_clk=0, the state stays 11 on the next cycle.
- R5: In state 01 or state 10 with slow_clk=1, the state holds on the next cycle for either value of data_in.
- R6: In state 01 or state 10 with slow_clk=0, state 01 moves to 11 and state 10 moves to 00.
- R7: q_out changes only on the step that leaves state 00 or state 11. Changing data_in while slow_clk stays high or stays low has no effect on q_out.
- R8: q_changed is 1 in exactly those cycles in which q_out differs from its value one cycle earlier, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that steps the machine |
| rst | input | 1 | Synchronous active-high reset to state 00 |
| slow_clk | input | 1 | Sampled level of the data-style clock |
| data_in | input | 1 | Data bit sampled on a capture step |
| q_out | output | 1 | Stored bit (state bit q) |
| p_out | output | 1 | Auxiliary state bit p |
| q_changed | output | 1 | One-cycle pulse when q_out takes a new value |

## Verification
The directed patterns each isolate one behaviour:

- **Rising edges with each data value.** These separate the two capture targets, 01 and 10.
- **Long high phases with data toggling.** These show whether the mixed states really ignore data.
- **Long low phases with data toggling.** These separate a correctly holding stable state from one that leaks data through.
- **Capturing the bit already stored.** Back-to-back edges that capture the same value must produce no change pulse. This tells a true change detector apart from one that fires on every capture.

A long run of random clock-input and data levels then drives every state through every input combination. Each step is compared against a table model held in the bench.

// File: rtl/pq_pkg.sv
package pq_pkg;
    typedef struct packed {
        logic p;
        logic q;
    } pq_state_t;

    localparam pq_state_t PQ_RESET = '{p: 1'b0, q: 1'b0};
endpackage

// File: rtl/pq_next_state.sv
module pq_next_state
    import pq_pkg::*;
(
    input  pq_state_t cur,
    input  logic      slow_clk,
    input  logic      data_in,
    output pq_state_t nxt
);
    logic stable;

    always_comb begin
        stable = (cur.p == cur.q);
        nxt    = cur;
        if (stable) begin
            if (slow_clk) begin
                nxt.p = ~data_in;
                nxt.q = data_in;
            end
        end else begin
            if (!slow_clk) begin
                nxt.p = cur.q;
                nxt.q = cur.q;
            end
        end
    end
endmodule

// File: rtl/pq_edge_register.sv
module pq_edge_register
    import pq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic slow_clk,
    input  logic data_in,
    output logic q_out,
    output logic p_out,
    output logic q_changed
);
    typedef struct packed {
        pq_state_t st;
        logic      chg;
    } regs_t;

    regs_t     r_q;
    regs_t     r_d;
    pq_state_t step_d;

    pq_next_state u_ns (
        .cur      (r_q.st),
        .slow_clk (slow_clk),
        .data_in  (data_in),
        .nxt      (step_d)
    );

    always_comb begin
        r_d.st  = step_d;
        r_d.chg = (step_d.q != r_q.st.q);
        if (rst) begin
            r_d.st  = PQ_RESET;
            r_d.chg = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign q_out     = r_q.st.q;
    assign p_out     = r_q.st.p;
    assign q_changed = r_q.chg;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!p_out && !q_out && !q_changed));

    assert_hold_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!p_out && !q_out && !slow_clk) |=> (!p_out && !q_out));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        ((p_out == q_out) && slow_clk) |=>
            (q_out == $past(data_in) && p_out == !$past(data_in)));

    assert_hold_low_R4: assert property (@(posedge clk) disable iff (rst)
        (p_out && q_out && !slow_clk) |=> (p_out && q_out));

    assert_hold_high_R5: assert property (@(posedge clk) disable iff (rst)
        ((p_out != q_out) && slow_clk) |=> ($stable(p_out) && $stable(q_out)));

    assert_settle_R6: assert property (@(posedge clk) disable iff (rst)
        ((p_out != q_out) && !slow_clk) |=>
            (p_out == $past(q_out) && q_out == $past(q_out)));

    assert_q_only_on_capture_R7: assert property (@(posedge clk) disable iff (rst)
        ((p_out != q_out) || !slow_clk) |=> $stable(q_out));

    assert_change_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q_changed == (q_out != $past(q_out))));
endmodule

// File: tb/sim_pq_edge_register.sv
module sim_pq_edge_register;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slow_clk = 1'b0;
    logic data_in = 1'b0;
    logic q_out, p_out, q_changed;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic mp, mq, mchg;

    always #4 clk = ~clk;

    pq_edge_register u0 (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .data_in(data_in),
        .q_out(q_out), .p_out(p_out), .q_changed(q_changed)
    );

    function automatic logic [1:0] model_next(logic p, logic q, logic c, logic d);
        if (p == q) return c ? {~d, d} : {p, q};
        else        return c ? {p, q} : {q, q};
    endfunction

    function automatic string tag_of(logic p, logic q, logic c);
        if (p == q && c)  return "R3";
        if (p == q && !p) return "R2";
        if (p == q)       return "R4";
        if (c)            return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {p,q,chg} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(logic c, logic d);
        logic [1:0] n;
        string tag;
        slow_clk = c;
        data_in  = d;
        tag = tag_of(mp, mq, c);
        n = model_next(mp, mq, c, d);
        mchg = (n[0] != mq);
        {mp, mq} = n;
        @(posedge clk);
        #1;
        check(tag, {p_out, q_out, q_changed}, {mp, mq, mchg});
        if (mchg) check("R8", {2'b00, q_changed}, 3'b001);
    endtask

    initial begin
        int unsigned r;
        mp = 0; mq = 0; mchg = 0;
        r = $urandom(32'd24681);
        repeat (3) @(posedge clk);
        #1;
        check("R1", {p_out, q_out, q_changed}, 3'b000);
        rst = 1'b0;
        step(0, 1); step(0, 0);                     // R2 hold in 00
        step(1, 1);                                 // R3 capture 1
        check("R8", {2'b00, q_changed}, 3'b001);
        step(1, 0); step(1, 1); step(1, 0);         // R5 data ignored while high
        check("R7", {2'b00, q_out}, 3'b001);
        step(0, 0);                                 // R6 01 -> 11
        step(0, 0); step(0, 1);                     // R4 hold in 11
        check("R7", {2'b00, q_out}, 3'b001);
        step(1, 1);                                 // R3 same value: no pulse
        check("R8", {2'b00, q_changed}, 3'b000);
        step(0, 0); step(1, 0);                     // R3 capture 0 from 11
        check("R8", {2'b00, q_changed}, 3'b001);
        step(1, 1); step(0, 1);                     // R6 10 -> 00
        check("R7", {2'b00, q_out}, 3'b000);
        step(1, 1);
        rst = 1'b1;
        mp = 0; mq = 0; mchg = 0;
        @(posedge clk); #1;
        check("R1", {p_out, q_out, q_changed}, 3'b000);
        rst = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            step(r[0] & r[1] | r[2] & r[0], r[3]);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule